// File: doc/BRIEF.md
# 8-bit accumulator ALU with flag register

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. Each cycle it takes an operation code, the accumulator value and a second operand. It then returns a result byte and a write-back enable without waiting for a clock edge. The five condition flags are sign, zero, aux carry, parity and carry. They live in a register inside the block. Operations read the current flags: carry for the through-carry forms, and both carries for the decimal adjust. The new flags are stored on the clock edge where the operation strobe is high.

The flags also appear as one packed byte, and the same byte can be loaded back, for example when a saved status word is restored. The surrounding datapath selects the operands and decides where the result goes. This block only computes.

Top module: `accum_alu`

## Requirements
- R1: After reset the flag byte reads 0x02. The layout is sign bit 7, zero bit 6, aux carry bit 4, parity bit 2, carry bit 0; bit 1 always reads 1 and bits 5 and 3 always read 0.
- R2: Add (code 0) and add-with-carry (code 1, carry flag as carry-in) return the low 8 bits of the sum. Carry is set when the 9-bit sum exceeds 0xFF, and aux carry when the low-nibble sum plus carry-in exceeds 0xF.
- R3: Subtract (code 2) and subtract-with-borrow (code 3, carry flag as borrow-in) return the wrapped difference. Carry is set when the unsigned difference borrows, and aux carry when the low-nibble difference minus borrow-in underflows.
- R4: Every operation that produces a value updates the value flags from it: zero when the value is 0, sign equal to bit 7, parity set for an even count of one bits. These operations are codes 0-3, 4-6, 7, 8-9 and 14.
- R5: AND (code 4), XOR (code 5) and OR (code 6) return the bitwise result, clear carry and leave aux carry unchanged.
- R6: Compare (code 7) sets every flag exactly as subtract would, and keeps write-back enable low.
- R7: Increment (code 8) and decrement (code 9) add or subtract one. Aux carry marks a low-nibble overflow on increment and a low-nibble underflow on decrement. Carry keeps its value.
- R8: Rotate left (code 10) and rotate right (code 11) move the bit shifted out into both carry and the opposite end. Through-carry left (code 12) and right (code 13) shift the old carry in and the bit shifted out into carry. Rotates change no other flag.
- R9: Decimal adjust (code 14) works in two steps. First, if the low nibble exceeds 9 or aux carry is set, it adds 6, and aux carry becomes whether that nibble overflowed (0 if no 6 was added). Second, if the high nibble of that value exceeds 9 or carry is set, it adds 0x60; carry is then set if it was already set or that addition overflows.
- R10: Complement (code 15) inverts the accumulator and changes no flag. Set-carry (code 16) forces carry to 1 and complement-carry (code 17) inverts it. Neither of the last two writes back.
- R11: Flags change only on a clock edge where the operation strobe or the flag-load strobe is high. A flag load takes bits 7, 6, 4, 2, 0 of the input byte and wins over a simultaneous operation.
- R12: Write-back enable is high only while the strobe is high with a value-producing code (0-6, 8-15). Codes 18 to 31 write nothing and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Operation strobe; flags update on this edge |
| op_code_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| flag_wr_i | input | 1 | Load the flag register from flag_wr_data_i |
| flag_wr_data_i | input | 8 | Packed flag byte to load |
| result_o | output | 8 | Result byte (combinational) |
| wb_en_o | output | 1 | Accumulator write-back enable |
| flag_byte_o | output | 8 | Packed current flags |

## Verification
All internal state is the five flag bits, and they appear on the flag byte one cycle after the edge that updates them. A wrong flag computation therefore shows on the next sample. A flag that should have been held shows as a changed bit in the cycle after an unrelated operation. A stale carry or aux carry also shows in the result byte of the next add-with-carry, subtract-with-borrow, through-carry rotate or decimal adjust, because those read the flags in the same cycle. The bench presets flags through the load port so that each consumer of carry and aux carry is checked with both values.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD    = 5'd0,
        OP_ADC    = 5'd1,
        OP_SUB    = 5'd2,
        OP_SBB    = 5'd3,
        OP_AND    = 5'd4,
        OP_XOR    = 5'd5,
        OP_OR     = 5'd6,
        OP_CMP    = 5'd7,
        OP_INC    = 5'd8,
        OP_DEC    = 5'd9,
        OP_ROL    = 5'd10,
        OP_ROR    = 5'd11,
        OP_ROLC   = 5'd12,
        OP_RORC   = 5'd13,
        OP_DECADJ = 5'd14,
        OP_CPL    = 5'd15,
        OP_SETC   = 5'd16,
        OP_CPLC   = 5'd17
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } alu_flags_t;

    function automatic logic [7:0] pack_flags(input alu_flags_t f);
        return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.cy};
    endfunction

    function automatic alu_flags_t unpack_flags(input logic [7:0] b);
        alu_flags_t f;
        f.s  = b[7];
        f.z  = b[6];
        f.ac = b[4];
        f.p  = b[2];
        f.cy = b[0];
        return f;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import accalu_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = NIB_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         cy_o,
    output logic         ac_o
);

    logic [W:0] full;
    logic [N:0] nib;

    always_comb begin
        if (sub_i) begin
            full = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
            nib  = {1'b0, a_i[N-1:0]} - {1'b0, b_i[N-1:0]} - {{N{1'b0}}, cin_i};
        end else begin
            full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
            nib  = {1'b0, a_i[N-1:0]} + {1'b0, b_i[N-1:0]} + {{N{1'b0}}, cin_i};
        end
    end

    assign res_o = full[W-1:0];
    assign cy_o  = full[W];
    assign ac_o  = nib[N];

endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import accalu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cy_o
);

    always_comb begin
        res_o = a_i;
        cy_o  = cin_i;
        case (op_i)
            OP_AND: res_o = a_i & b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_CPL: res_o = ~a_i;
            OP_ROL: begin
                res_o = {a_i[W-2:0], a_i[W-1]};
                cy_o  = a_i[W-1];
            end
            OP_ROR: begin
                res_o = {a_i[0], a_i[W-1:1]};
                cy_o  = a_i[0];
            end
            OP_ROLC: begin
                res_o = {a_i[W-2:0], cin_i};
                cy_o  = a_i[W-1];
            end
            OP_RORC: begin
                res_o = {cin_i, a_i[W-1:1]};
                cy_o  = a_i[0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/alu_decadj.sv
module alu_decadj
    import accalu_pkg::*;
#(
    parameter int LIMIT = 9
) (
    input  logic [7:0] a_i,
    input  logic       ac_i,
    input  logic       cy_i,
    output logic [7:0] res_o,
    output logic       ac_o,
    output logic       cy_o
);

    localparam logic [NIB_W-1:0] LIM = NIB_W'(LIMIT);
    localparam logic [NIB_W:0]   SIX = (NIB_W+1)'(6);

    logic           adj_lo;
    logic           adj_hi;
    logic [NIB_W:0] lo_sum;
    logic [NIB_W:0] hi_sum;

    always_comb begin
        adj_lo = (a_i[3:0] > LIM) || ac_i;
        lo_sum = {1'b0, a_i[3:0]} + (adj_lo ? SIX : '0);
        // carry out of the low nibble propagates into the high nibble
        hi_sum = {1'b0, a_i[7:4]} + {{NIB_W{1'b0}}, lo_sum[NIB_W]};
        adj_hi = (hi_sum[3:0] > LIM) || cy_i || hi_sum[NIB_W];
        ac_o   = adj_lo & lo_sum[NIB_W];
        cy_o   = cy_i | hi_sum[NIB_W];
        if (adj_hi) begin
            cy_o   = cy_o | ((({1'b0, hi_sum[3:0]} + SIX) >> NIB_W) != '0);
            res_o  = {hi_sum[3:0] + 4'd6, lo_sum[3:0]};
        end else begin
            res_o  = {hi_sum[3:0], lo_sum[3:0]};
        end
    end

endmodule

// File: rtl/accum_alu.sv
module accum_alu
    import accalu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        op_valid_i,
    input  logic [4:0]  op_code_i,
    input  logic [7:0]  acc_i,
    input  logic [7:0]  opnd_i,
    input  logic        flag_wr_i,
    input  logic [7:0]  flag_wr_data_i,
    output logic [7:0]  result_o,
    output logic        wb_en_o,
    output logic [7:0]  flag_byte_o
);

    typedef struct packed {
        alu_flags_t flags;
    } state_t;

    state_t  s_d, s_q;
    alu_op_e op;

    logic [DATA_W-1:0] as_b, as_res, bo_res, da_res;
    logic              as_cin, as_sub, as_cy, as_ac, bo_cy, da_ac, da_cy;

    assign op = alu_op_e'(op_code_i);

    assign as_b   = (op == OP_INC || op == OP_DEC) ? DATA_W'(1) : opnd_i;
    assign as_cin = (op == OP_ADC || op == OP_SBB) ? s_q.flags.cy : 1'b0;
    assign as_sub = (op == OP_SUB || op == OP_SBB || op == OP_CMP || op == OP_DEC);

    alu_addsub #(.W(DATA_W), .N(NIB_W)) u_addsub (
        .a_i   (acc_i),
        .b_i   (as_b),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .res_o (as_res),
        .cy_o  (as_cy),
        .ac_o  (as_ac)
    );

    alu_bitops #(.W(DATA_W)) u_bitops (
        .op_i  (op),
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .cin_i (s_q.flags.cy),
        .res_o (bo_res),
        .cy_o  (bo_cy)
    );

    alu_decadj #(.LIMIT(9)) u_decadj (
        .a_i   (acc_i),
        .ac_i  (s_q.flags.ac),
        .cy_i  (s_q.flags.cy),
        .res_o (da_res),
        .ac_o  (da_ac),
        .cy_o  (da_cy)
    );

    logic [DATA_W-1:0] res_d, zsp_val;
    logic              wb_d, zsp_upd;
    alu_flags_t        f_d;

    always_comb begin
        res_d   = acc_i;
        wb_d    = 1'b0;
        zsp_upd = 1'b0;
        zsp_val = as_res;
        f_d     = s_q.flags;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                res_d   = as_res;
                wb_d    = 1'b1;
                f_d.cy  = as_cy;
                f_d.ac  = as_ac;
                zsp_upd = 1'b1;
            end
            OP_CMP: begin
                f_d.cy  = as_cy;
                f_d.ac  = as_ac;
                zsp_upd = 1'b1;
            end
            OP_INC, OP_DEC: begin
                res_d   = as_res;
                wb_d    = 1'b1;
                f_d.ac  = as_ac;
                zsp_upd = 1'b1;
            end
            OP_AND, OP_XOR, OP_OR: begin
                res_d   = bo_res;
                wb_d    = 1'b1;
                f_d.cy  = 1'b0;
                zsp_val = bo_res;
                zsp_upd = 1'b1;
            end
            OP_ROL, OP_ROR, OP_ROLC, OP_RORC: begin
                res_d   = bo_res;
                wb_d    = 1'b1;
                f_d.cy  = bo_cy;
            end
            OP_CPL: begin
                res_d   = bo_res;
                wb_d    = 1'b1;
            end
            OP_DECADJ: begin
                res_d   = da_res;
                wb_d    = 1'b1;
                f_d.ac  = da_ac;
                f_d.cy  = da_cy;
                zsp_val = da_res;
                zsp_upd = 1'b1;
            end
            OP_SETC: f_d.cy = 1'b1;
            OP_CPLC: f_d.cy = ~s_q.flags.cy;
            default: ;
        endcase
        if (zsp_upd) begin
            f_d.z = (zsp_val == '0);
            f_d.s = zsp_val[DATA_W-1];
            f_d.p = ~^zsp_val;
        end

        s_d = s_q;
        if (flag_wr_i) begin
            s_d.flags = unpack_flags(flag_wr_data_i);
        end else if (op_valid_i) begin
            s_d.flags = f_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign result_o    = res_d;
    assign wb_en_o     = op_valid_i & wb_d;
    assign flag_byte_o = pack_flags(s_q.flags);

endmodule

// File: rtl/accum_alu_chk.sv
module accum_alu_chk
    import accalu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid_i,
    input logic [4:0] op_code_i,
    input logic       flag_wr_i,
    input logic [7:0] result_o,
    input logic       wb_en_o,
    input logic [7:0] flag_byte_o
);

    logic op_go;
    logic zsp_op;
    logic logic_op;
    logic rot_op;

    assign op_go    = op_valid_i && !flag_wr_i;
    assign logic_op = (op_code_i == OP_AND) || (op_code_i == OP_XOR) || (op_code_i == OP_OR);
    assign rot_op   = (op_code_i >= OP_ROL) && (op_code_i <= OP_RORC);
    assign zsp_op   = (op_code_i <= OP_OR) || (op_code_i == OP_INC) ||
                      (op_code_i == OP_DEC) || (op_code_i == OP_DECADJ);

    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_byte_o[1] && !flag_byte_o[3] && !flag_byte_o[5]); // R1

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        op_go && zsp_op |=> flag_byte_o[6] == ($past(result_o) == 8'h00)); // R4

    AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        op_go && zsp_op |=> flag_byte_o[7] == $past(result_o[7])); // R4

    AST_LOGIC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        op_go && logic_op |=> !flag_byte_o[0]); // R5

    AST_CMP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && op_code_i == OP_CMP |-> !wb_en_o); // R6

    AST_INCDEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        op_go && (op_code_i == OP_INC || op_code_i == OP_DEC) |=> $stable(flag_byte_o[0])); // R7

    AST_ROT_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        op_go && rot_op |=> $stable(flag_byte_o[7:1])); // R8

    AST_CPL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        op_go && op_code_i == OP_CPL |=> $stable(flag_byte_o)); // R10

    AST_SETC: assert property (@(posedge clk) disable iff (!rst_n)
        op_go && op_code_i == OP_SETC |=> flag_byte_o[0]); // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i && !flag_wr_i |=> $stable(flag_byte_o)); // R11

    AST_WB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> op_valid_i && op_code_i <= OP_CPL && op_code_i != OP_CMP); // R12

endmodule

bind accum_alu accum_alu_chk i_accum_alu_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid_i  (op_valid_i),
    .op_code_i   (op_code_i),
    .flag_wr_i   (flag_wr_i),
    .result_o    (result_o),
    .wb_en_o     (wb_en_o),
    .flag_byte_o (flag_byte_o)
);

// File: tb/test_accum_alu.sv
`timescale 1ns/1ps
module test_accum_alu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid_i = 1'b0;
    logic [4:0] op_code_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic       flag_wr_i = 1'b0;
    logic [7:0] flag_wr_data_i = '0;
    logic [7:0] result_o;
    logic       wb_en_o;
    logic [7:0] flag_byte_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    accum_alu i_accum_alu (
        .clk            (clk),
        .rst_n          (rst_n),
        .op_valid_i     (op_valid_i),
        .op_code_i      (op_code_i),
        .acc_i          (acc_i),
        .opnd_i         (opnd_i),
        .flag_wr_i      (flag_wr_i),
        .flag_wr_data_i (flag_wr_data_i),
        .result_o       (result_o),
        .wb_en_o        (wb_en_o),
        .flag_byte_o    (flag_byte_o)
    );

    logic [7:0] r, f;
    logic       w;

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic load_flags(input logic [7:0] v);
        @(negedge clk);
        flag_wr_i = 1'b1;
        flag_wr_data_i = v;
        @(negedge clk);
        flag_wr_i = 1'b0;
    endtask

    task automatic run_op(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        op_valid_i = 1'b1;
        op_code_i = op;
        acc_i = a;
        opnd_i = b;
        #1;
        r = result_o;
        w = wb_en_o;
        @(negedge clk);
        op_valid_i = 1'b0;
        f = flag_byte_o;
    endtask

    task automatic t_reset();
        check("R1", "reset flags", flag_byte_o, 8'h02);
    endtask

    task automatic t_add();
        load_flags(8'h00);
        run_op(5'd0, 8'h3A, 8'hC6);
        check("R2", "add result", r, 8'h00);
        check("R4", "add flags", f, 8'h57);
        check("R12", "add wb", {7'd0, w}, 8'h01);
        run_op(5'd1, 8'h0F, 8'h00);
        check("R2", "adc result", r, 8'h10);
        check("R2", "adc flags", f, 8'h12);
    endtask

    task automatic t_sub();
        load_flags(8'h00);
        run_op(5'd2, 8'h10, 8'h01);
        check("R3", "sub result", r, 8'h0F);
        check("R3", "sub flags", f, 8'h16);
        run_op(5'd2, 8'h05, 8'h07);
        check("R3", "sub borrow result", r, 8'hFE);
        check("R3", "sub borrow flags", f, 8'h93);
        run_op(5'd3, 8'h20, 8'h10);
        check("R3", "sbb result", r, 8'h0F);
        check("R3", "sbb flags", f, 8'h16);
    endtask

    task automatic t_cmp();
        load_flags(8'h00);
        run_op(5'd7, 8'h40, 8'h40);
        check("R6", "cmp equal flags", f, 8'h46);
        check("R6", "cmp wb", {7'd0, w}, 8'h00);
        run_op(5'd7, 8'h01, 8'h02);
        check("R6", "cmp less flags", f, 8'h97);
    endtask

    task automatic t_logic();
        load_flags(8'h03);
        run_op(5'd4, 8'hF0, 8'h3C);
        check("R5", "and result", r, 8'h30);
        check("R5", "and flags", f, 8'h06);
        load_flags(8'h13);
        run_op(5'd5, 8'h55, 8'h55);
        check("R5", "xor result", r, 8'h00);
        check("R5", "xor flags keep ac", f, 8'h56);
        load_flags(8'h03);
        run_op(5'd6, 8'h80, 8'h01);
        check("R5", "or result", r, 8'h81);
        check("R5", "or flags", f, 8'h86);
    endtask

    task automatic t_incdec();
        load_flags(8'h03);
        run_op(5'd8, 8'h0F, 8'h00);
        check("R7", "inc result", r, 8'h10);
        check("R7", "inc flags", f, 8'h13);
        run_op(5'd9, 8'h00, 8'h00);
        check("R7", "dec result", r, 8'hFF);
        check("R7", "dec flags", f, 8'h97);
        load_flags(8'h02);
        run_op(5'd8, 8'hFF, 8'h00);
        check("R7", "inc wrap result", r, 8'h00);
        check("R7", "inc wrap flags", f, 8'h56);
    endtask

    task automatic t_rot();
        load_flags(8'hD6);
        run_op(5'd10, 8'h81, 8'h00);
        check("R8", "rol result", r, 8'h03);
        check("R8", "rol flags", f, 8'hD7);
        load_flags(8'h02);
        run_op(5'd11, 8'h01, 8'h00);
        check("R8", "ror result", r, 8'h80);
        check("R8", "ror flags", f, 8'h03);
        load_flags(8'h02);
        run_op(5'd12, 8'h80, 8'h00);
        check("R8", "rolc c0 result", r, 8'h00);
        check("R8", "rolc c0 flags", f, 8'h03);
        run_op(5'd12, 8'h00, 8'h00);
        check("R8", "rolc c1 result", r, 8'h01);
        check("R8", "rolc c1 flags", f, 8'h02);
        load_flags(8'h03);
        run_op(5'd13, 8'h01, 8'h00);
        check("R8", "rorc c1 result", r, 8'h80);
        check("R8", "rorc c1 flags", f, 8'h03);
        load_flags(8'h02);
        run_op(5'd13, 8'h02, 8'h00);
        check("R8", "rorc c0 result", r, 8'h01);
        check("R8", "rorc c0 flags", f, 8'h02);
    endtask

    task automatic t_decadj();
        load_flags(8'h02);
        run_op(5'd14, 8'h9B, 8'h00);
        check("R9", "adjust both result", r, 8'h01);
        check("R9", "adjust both flags", f, 8'h13);
        load_flags(8'h12);
        run_op(5'd14, 8'h15, 8'h00);
        check("R9", "adjust ac result", r, 8'h1B);
        check("R9", "adjust ac flags", f, 8'h06);
        load_flags(8'h03);
        run_op(5'd14, 8'h12, 8'h00);
        check("R9", "adjust carry result", r, 8'h72);
        check("R9", "adjust carry flags", f, 8'h07);
        load_flags(8'h02);
        run_op(5'd14, 8'h00, 8'h00);
        check("R9", "adjust none flags", f, 8'h46);
    endtask

    task automatic t_carryops();
        load_flags(8'hD7);
        run_op(5'd15, 8'h5A, 8'h00);
        check("R10", "cpl result", r, 8'hA5);
        check("R10", "cpl flags", f, 8'hD7);
        load_flags(8'h02);
        run_op(5'd16, 8'h00, 8'h00);
        check("R10", "setc flags", f, 8'h03);
        check("R10", "setc wb", {7'd0, w}, 8'h00);
        run_op(5'd17, 8'h00, 8'h00);
        check("R10", "cplc flags", f, 8'h02);
        run_op(5'd17, 8'h00, 8'h00);
        check("R10", "cplc again flags", f, 8'h03);
    endtask

    task automatic t_strobe();
        load_flags(8'h02);
        @(negedge clk);
        op_code_i = 5'd0;
        acc_i = 8'hFF;
        opnd_i = 8'h01;
        #1;
        check("R12", "wb without strobe", {7'd0, wb_en_o}, 8'h00);
        @(negedge clk);
        check("R11", "flags without strobe", flag_byte_o, 8'h02);
        load_flags(8'hFF);
        check("R11", "load masks fixed bits", flag_byte_o, 8'hD7);
        @(negedge clk);
        flag_wr_i = 1'b1;
        flag_wr_data_i = 8'h00;
        op_valid_i = 1'b1;
        op_code_i = 5'd16;
        @(negedge clk);
        flag_wr_i = 1'b0;
        op_valid_i = 1'b0;
        check("R11", "load wins over op", flag_byte_o, 8'h02);
        load_flags(8'h13);
        run_op(5'd31, 8'h00, 8'h00);
        check("R12", "unused code flags", f, 8'h13);
        check("R12", "unused code wb", {7'd0, w}, 8'h00);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_incdec();
        t_rot();
        t_decadj();
        t_carryops();
        t_strobe();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule